// File: doc/BRIEF.md
# Motor Mode Sequencer with Brake

This block is the top-level mode controller of a three-phase brushless motor driver. It takes the stop/run request (active low), the direction request and four protection inputs: a filtered undervoltage comparator, an over-temperature comparator, a short-circuit detect and a latched stall-protect flag. From these it produces a two-bit override code for the phase commutation logic, which selects normal commutation, all phases low or all phases high-impedance. It also drives enables for the high-side charge pump and the Hall sensor supply, and it latches the direction the commutator is to use.

All timing derives from a clock prescaler. The prescaler produces one tick every `TICK_DIV` clocks. The wake-up delay, the brake period, the undervoltage persistence time and the undervoltage release time are parameters counted in ticks. After a start request the drive stays off until the gate supply has had time to wake up. Leaving commutation, whether for a stop, a fault-driven suspend or a direction reversal, always holds all three phases low for a timed brake first. Over-temperature and short-circuit act on the override at once, in the same cycle, and do not change the sequencing state.

Top module: `motor_mode_seq`

## Requirements
- R1: A change of `dir_req` while driving selects all-low (`01`) on the cycle after the change and holds it for `BRAKE_TICKS` ticks. Normal drive (`00`) then resumes, with `dir_q` equal to the new direction. `dir_q` never changes while normal drive continues.
- R2: A stop request while driving (`run_n` high) passes through all-low for `BRAKE_TICKS` ticks and then reaches high-impedance (`10`) with `cp_en` low. This also holds when the stop arrives during a reversal brake. Drive never goes directly to the off state.
- R3: A stop request during the wake-up delay returns to the off state on the next cycle, without a brake.
- R4: `uv_in` must stay high for `SPND_TICKS` consecutive ticks before it acts as a stop. A shorter pulse has no effect on the drive.
- R5: Once undervoltage has acted, it is released only after `uv_in` has stayed low for `WAIT_TICKS` consecutive ticks. A high pulse during that time restarts the count. In the off state, `cp_en` and `hall_en` are both low and the override is high-impedance.
- R6: While `stall_prot` is high, the block behaves as for a stop request: it brakes and then suspends. It stays off until the flag clears.
- R7: After a start request from the off state, `cp_en` and `hall_en` rise on the next cycle. The override stays high-impedance for `WAKE_TICKS` ticks before normal drive begins.
- R8: `ot_in` high forces the override to high-impedance in the same cycle, whatever the other inputs are. When it clears, the override returns to the sequencer's choice.
- R9: `sc_in` high with `ot_in` low forces the override to all-low in the same cycle.
- R10: The override encoding is `00` for normal commutation, `01` for all phases low and `10` for all high-impedance. `11` never appears. After reset the block is off: override `10`, both enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timebase clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_n | input | 1 | Run request, low = run, high = stop |
| dir_req | input | 1 | Requested rotation direction |
| uv_in | input | 1 | Supply-low comparator output, high = low supply |
| ot_in | input | 1 | Over-temperature comparator, high = too hot |
| sc_in | input | 1 | Short-circuit detect, high = short |
| stall_prot | input | 1 | Latched stall-protect flag |
| phase_ovr | output | 2 | Phase override code for the commutator |
| cp_en | output | 1 | Charge-pump enable |
| hall_en | output | 1 | Hall sensor supply enable |
| dir_q | output | 1 | Direction currently applied to commutation |

## Verification
The checker evaluates these properties on every cycle:
- the fault overrides act in the same cycle and thermal outranks short-circuit;
- the code `11` never appears;
- the off state always pairs with high-impedance outputs and both enables low;
- normal drive is never followed directly by the off state;
- the direction does not change during uninterrupted drive.

The exact lengths of the wake-up, brake, persistence and release windows, and the count restarting after a glitch, can be shown only by the bench scenarios. The same applies to aborting the wake-up and to resuming in the new direction after a reversal, since these depend on counted histories.

// File: rtl/mms_pkg.sv
package mms_pkg;
   typedef enum logic [1:0] {
      OVR_DRIVE = 2'b00,
      OVR_LOW   = 2'b01,
      OVR_HIZ   = 2'b10
   } ovr_e;

   typedef enum logic [1:0] {
      ST_OFF   = 2'b00,
      ST_WAKE  = 2'b01,
      ST_RUN   = 2'b10,
      ST_BRAKE = 2'b11
   } mode_e;
endpackage

// File: rtl/mms_tick.sv
module mms_tick #(
   parameter int DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(DIV);
         localparam logic [DW-1:0] LAST = DW'(DIV - 1);
         logic [DW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/mms_uv_filter.sv
module mms_uv_filter #(
   parameter int W    = 8,
   parameter int SPND = 10,
   parameter int WAIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic uv_in,
   output logic uv_rst
);
   localparam logic [W-1:0] SPND_L = W'(SPND - 1);
   localparam logic [W-1:0] WAIT_L = W'(WAIT - 1);

   logic [W-1:0] cnt;
   logic [W-1:0] lim;

   assign lim = uv_rst ? WAIT_L : SPND_L;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uv_rst <= 1'b0;
         cnt    <= '0;
      end else if (uv_in == uv_rst) begin
         cnt <= '0;
      end else if (tick) begin
         if (cnt == lim) begin
            uv_rst <= ~uv_rst;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mms_timer.sv
module mms_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         expire
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (clr) cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   assign expire = tick && (cnt == limit);
endmodule

// File: rtl/motor_mode_seq.sv
module motor_mode_seq #(
   parameter int TICK_DIV    = 10,
   parameter int BRAKE_TICKS = 2000,
   parameter int WAKE_TICKS  = 100,
   parameter int SPND_TICKS  = 10,
   parameter int WAIT_TICKS  = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_n,
   input  logic       dir_req,
   input  logic       uv_in,
   input  logic       ot_in,
   input  logic       sc_in,
   input  logic       stall_prot,
   output logic [1:0] phase_ovr,
   output logic       cp_en,
   output logic       hall_en,
   output logic       dir_q
);
   import mms_pkg::*;

   localparam int MAX_A = (BRAKE_TICKS > WAKE_TICKS) ? BRAKE_TICKS : WAKE_TICKS;
   localparam int MAX_B = (SPND_TICKS > WAIT_TICKS) ? SPND_TICKS : WAIT_TICKS;
   localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CW    = $clog2(MAX_T + 1);
   localparam logic [CW-1:0] BRAKE_L = CW'(BRAKE_TICKS - 1);
   localparam logic [CW-1:0] WAKE_L  = CW'(WAKE_TICKS - 1);

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (BRAKE_TICKS < 1 || WAKE_TICKS < 1) begin : g_bad_seq
         $error("brake and wake durations must be at least one tick");
      end
      if (SPND_TICKS < 1 || WAIT_TICKS < 1) begin : g_bad_uv
         $error("undervoltage windows must be at least one tick");
      end
   endgenerate

   logic         tick;
   logic         uv_rst;
   logic         stop_req;
   logic         expire;
   logic         state_chg;
   logic [CW-1:0] limit;
   logic [1:0]   st_ovr;
   mode_e        state, state_nx;

   mms_tick #(.DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   mms_uv_filter #(.W(CW), .SPND(SPND_TICKS), .WAIT(WAIT_TICKS)) u_uv (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .uv_in  (uv_in),
      .uv_rst (uv_rst)
   );

   assign limit     = (state == ST_WAKE) ? WAKE_L : BRAKE_L;
   assign state_chg = (state_nx != state);

   mms_timer #(.W(CW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (state_chg),
      .tick   (tick),
      .limit  (limit),
      .expire (expire)
   );

   assign stop_req = run_n | uv_rst | stall_prot;

   always_comb begin
      state_nx = state;
      case (state)
         ST_OFF:   if (!stop_req) state_nx = ST_WAKE;
         ST_WAKE:  if (stop_req) state_nx = ST_OFF;
                   else if (expire) state_nx = ST_RUN;
         ST_RUN:   if (stop_req || (dir_req != dir_q)) state_nx = ST_BRAKE;
         ST_BRAKE: if (expire) state_nx = stop_req ? ST_OFF : ST_RUN;
         default:  state_nx = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_OFF;
         dir_q <= 1'b0;
      end else begin
         state <= state_nx;
         if (state != ST_RUN && state_nx == ST_RUN) dir_q <= dir_req;
      end
   end

   always_comb begin
      case (state)
         ST_RUN:   st_ovr = OVR_DRIVE;
         ST_BRAKE: st_ovr = OVR_LOW;
         default:  st_ovr = OVR_HIZ;
      endcase
   end

   always_comb begin
      if (ot_in)      phase_ovr = OVR_HIZ;
      else if (sc_in) phase_ovr = OVR_LOW;
      else            phase_ovr = st_ovr;
   end

   assign cp_en   = (state != ST_OFF);
   assign hall_en = (state != ST_OFF);
endmodule

// File: rtl/mms_check.sv
module mms_check (
   input logic       clk,
   input logic       rst_n,
   input logic       ot_in,
   input logic       sc_in,
   input logic [1:0] phase_ovr,
   input logic [1:0] st_ovr,
   input logic       cp_en,
   input logic       hall_en,
   input logic       dir_q
);
   AST_THERM_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      ot_in |-> phase_ovr == 2'b10);                                    // R8
   AST_SHORT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_in && !ot_in) |-> phase_ovr == 2'b01);                        // R9
   AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rst_n)
      phase_ovr != 2'b11);                                              // R10
   AST_OFF_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (!cp_en && !ot_in && !sc_in) |-> (phase_ovr == 2'b10 && !hall_en)); // R5
   AST_NO_ABRUPT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_ovr == 2'b00) |=> cp_en);                                     // R2
   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_ovr == 2'b00 && $past(st_ovr) == 2'b00) |-> $stable(dir_q));  // R1
endmodule

bind motor_mode_seq mms_check u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ot_in     (ot_in),
   .sc_in     (sc_in),
   .phase_ovr (phase_ovr),
   .st_ovr    (st_ovr),
   .cp_en     (cp_en),
   .hall_en   (hall_en),
   .dir_q     (dir_q)
);

// File: tb/sim_motor_mode_seq.sv
`timescale 1ns/1ps
module sim_motor_mode_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_n = 1'b1, dir_req = 1'b0, uv_in = 1'b0;
   logic ot_in = 1'b0, sc_in = 1'b0, stall_prot = 1'b0;
   logic [1:0] phase_ovr;
   logic cp_en, hall_en, dir_q;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [1:0] DRV = 2'b00, LOW = 2'b01, HIZ = 2'b10;
   // {ot_in, sc_in, expected override} applied while driving
   localparam logic [3:0] VEC [4] = '{4'b0000, 4'b0101, 4'b1010, 4'b1110};

   always #4 clk = ~clk;

   motor_mode_seq #(
      .TICK_DIV(1), .BRAKE_TICKS(8), .WAKE_TICKS(6),
      .SPND_TICKS(5), .WAIT_TICKS(7)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .run_n(run_n), .dir_req(dir_req),
      .uv_in(uv_in), .ot_in(ot_in), .sc_in(sc_in), .stall_prot(stall_prot),
      .phase_ovr(phase_ovr), .cp_en(cp_en), .hall_en(hall_en), .dir_q(dir_q)
   );

   task automatic tk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      tk(3);
      rst_n = 1'b1;
      tk(1);
      chk("R10 reset ovr", phase_ovr, HIZ);
      chk("R10 reset cp_en", cp_en, 0);
      chk("R10 reset hall_en", hall_en, 0);

      // R7 wake-up delay
      run_n = 1'b0;
      tk(1);
      chk("R7 cp_en on", cp_en, 1);
      chk("R7 hall_en on", hall_en, 1);
      tk(5);
      chk("R7 still hiz end of wake", phase_ovr, HIZ);
      tk(1);
      chk("R7 drive after wake", phase_ovr, DRV);
      chk("R1 initial dir", dir_q, 0);

      // R8 R9 override vectors
      for (int i = 0; i < 4; i++) begin
         ot_in = VEC[i][3];
         sc_in = VEC[i][2];
         #1;
         chk("R8 R9 override table", phase_ovr, VEC[i][1:0]);
         ot_in = 1'b0;
         sc_in = 1'b0;
         #1;
      end
      ot_in = 1'b1;
      tk(3);
      chk("R8 thermal held", phase_ovr, HIZ);
      ot_in = 1'b0;
      #1;
      chk("R8 thermal released", phase_ovr, DRV);

      // R1 reversal
      dir_req = 1'b1;
      tk(1);
      chk("R1 brake start", phase_ovr, LOW);
      tk(7);
      chk("R1 brake last cycle", phase_ovr, LOW);
      tk(1);
      chk("R1 resume drive", phase_ovr, DRV);
      chk("R1 new dir", dir_q, 1);

      // R4 short undervoltage ignored
      uv_in = 1'b1;
      tk(4);
      uv_in = 1'b0;
      tk(3);
      chk("R4 short dip ignored", phase_ovr, DRV);

      // R4 persistent undervoltage
      uv_in = 1'b1;
      tk(5);
      chk("R4 before act", phase_ovr, DRV);
      tk(1);
      chk("R4 brake on uv", phase_ovr, LOW);
      tk(7);
      chk("R2 uv brake last", phase_ovr, LOW);
      tk(1);
      chk("R2 uv off hiz", phase_ovr, HIZ);
      chk("R5 uv off cp", cp_en, 0);
      chk("R5 uv off hall", hall_en, 0);

      // R5 release with restart
      uv_in = 1'b0;
      tk(3);
      uv_in = 1'b1;
      tk(1);
      uv_in = 1'b0;
      tk(7);
      chk("R5 release not yet", cp_en, 0);
      tk(1);
      chk("R5 released wake", cp_en, 1);
      tk(6);
      chk("R7 drive after uv", phase_ovr, DRV);

      // R6 stall protect
      stall_prot = 1'b1;
      tk(1);
      chk("R6 stall brake", phase_ovr, LOW);
      tk(8);
      chk("R6 stall off", phase_ovr, HIZ);
      tk(4);
      chk("R6 stays off", cp_en, 0);
      stall_prot = 1'b0;
      tk(1);
      chk("R6 restart wake", cp_en, 1);

      // R3 stop during wake
      tk(2);
      run_n = 1'b1;
      tk(1);
      chk("R3 abort wake cp", cp_en, 0);
      chk("R3 abort wake ovr", phase_ovr, HIZ);

      // R2 stop from drive
      run_n = 1'b0;
      tk(7);
      chk("R7 drive again", phase_ovr, DRV);
      run_n = 1'b1;
      tk(1);
      chk("R2 stop brake", phase_ovr, LOW);
      chk("R2 cp during brake", cp_en, 1);
      tk(7);
      chk("R2 stop brake last", phase_ovr, LOW);
      tk(1);
      chk("R2 stop off", phase_ovr, HIZ);
      chk("R5 stop hall off", hall_en, 0);

      // R2 stop during reversal brake
      run_n = 1'b0;
      tk(7);
      chk("R7 drive third", phase_ovr, DRV);
      dir_req = 1'b0;
      tk(1);
      chk("R1 reversal brake", phase_ovr, LOW);
      run_n = 1'b1;
      tk(7);
      chk("R2 rev brake holds", phase_ovr, LOW);
      tk(1);
      chk("R2 rev then off", phase_ovr, HIZ);
      chk("R2 rev then cp off", cp_en, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule